// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Block

This block is one configurable logic tile of a CPLD-style fabric. It takes 36 routed signals and offers each one in both polarities, which gives a field of 72 literals. A programmable AND plane forms 83 product terms from that field. Eighty of these terms are general purpose. A steering stage hands them out to 16 macrocells, and each macrocell ORs the terms it receives. The remaining three terms have fixed jobs: one is an asynchronous set, one is an asynchronous reset, and one is a clock that every macrocell can share.

Each macrocell passes its OR result straight through or holds it in a flip-flop. The flip-flop is clocked either by the global clock or by the shared product-term clock. The whole configuration is one flat bit vector. It is shifted in serially while a load enable is held. The logic stays inert until a load has completed, and the 16 macrocell outputs are the only outputs of the block.

Top module: `pterm_lb`

## Requirements
- R1: Literal index l (0..71) of a product term is input in_i[l] for l < 36 and the inverted input ~in_i[l-36] for l >= 36. A programmed term is the AND of all its selected literals. Configuration bit p*72+l selects literal l into term p.
- R2: A product term with no literal selected evaluates to 0, so it never drives a macrocell high.
- R3: General term t (0..79) belongs to group t/20. Configuration bit 5976+4*t+k steers the term to macrocell 4*(t/20)+k. One term may feed several macrocells of its group. A macrocell output is the OR of its steered terms, and it is 0 when no term is steered to it.
- R4: A macrocell sums at most 16 terms. Of the terms steered to it, only the 16 with the lowest indices count.
- R5: When mode bit 6296+2*m is 0, macrocell m is combinational: its output follows its OR result within the same cycle, and the set and reset terms do not affect it.
- R6: When mode bit 6296+2*m is 1 and mode bit 6297+2*m is 0, macrocell m registers its OR result on the rising edge of clk_i.
- R7: When mode bits 6296+2*m and 6297+2*m are both 1, macrocell m registers on the rising edge of product term 82 and ignores clk_i.
- R8: Product term 80 forces every registered macrocell to 1 at once, without waiting for a clock edge.
- R9: Product term 81 forces every registered macrocell to 0 at once, and it wins over term 80 when both are active.
- R10: Each rising clk_i edge with cfg_en_i high shifts cfg_di_i into configuration bit 0, and every other bit moves up by one place. The first bit shifted in therefore ends at bit 6327. While loading, and before any load has completed, mc_o is all zero. The first edge with cfg_en_i low after a load makes the configuration active.
- R11: rst_ni low clears the configuration and every macrocell register, and drives mc_o to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Global clock for the configuration chain and for globally clocked macrocells |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_en_i | input | 1 | Configuration shift enable |
| cfg_di_i | input | 1 | Serial configuration data |
| in_i | input | 36 | Routed input signals |
| mc_o | output | 16 | Macrocell outputs |

## Verification
On every cycle, the assertions check the following:
- reset wins over set on the registered macrocells;
- the set term forces a 1;
- a globally clocked register holds the OR result of the previous edge;
- the shift chain advances and takes the serial input;
- the outputs stay low during a load.

Only the bench scenarios can show the rest. These cover:
- the full AND/OR function under random configurations, checked against an independent sum-of-products model;
- the 16-term cap and sharing within a group of four;
- blank terms giving 0;
- the product-term clock capturing data while the global clock does not.

// File: rtl/pterm_lb_pkg.sv
package pterm_lb_pkg;
  // per-macrocell mode: bit 0 = registered, bit 1 = product-term clock
  typedef struct packed {
    logic pt_clk;
    logic reg_en;
  } mc_mode_t;
endpackage

// File: rtl/pterm_lb_cfg_chain.sv
module pterm_lb_cfg_chain #(
  parameter int unsigned CFG_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             cfg_di_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             valid_o
);
  logic loaded_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o    <= '0;
      loaded_q <= 1'b0;
      valid_o  <= 1'b0;
    end else if (cfg_en_i) begin
      cfg_o    <= {cfg_o[CFG_W-2:0], cfg_di_i};
      loaded_q <= 1'b1;
      valid_o  <= 1'b0;
    end else begin
      valid_o  <= loaded_q;
    end
  end

  // R10
  load_blocks_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> !valid_o);

  // R10
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> cfg_o[0] == $past(cfg_di_i));
endmodule

// File: rtl/pterm_lb_and_plane.sv
module pterm_lb_and_plane #(
  parameter int unsigned N_IN = 36,
  parameter int unsigned N_PT = 83,
  localparam int unsigned N_LIT = 2 * N_IN
) (
  input  logic [N_IN-1:0]       in_i,
  input  logic [N_PT*N_LIT-1:0] sel_i,
  input  logic                  en_i,
  output logic [N_PT-1:0]       pt_o
);
  logic [N_LIT-1:0] lit;
  assign lit = {~in_i, in_i};

  for (genvar p = 0; p < N_PT; p++) begin : g_pt
    logic [N_LIT-1:0] sel;
    assign sel     = sel_i[p*N_LIT +: N_LIT];
    // blank term reads 0, not 1
    assign pt_o[p] = en_i & (|sel) & (&(lit | ~sel));
  end
endmodule

// File: rtl/pterm_lb_steer.sv
module pterm_lb_steer #(
  parameter int unsigned N_MC   = 16,
  parameter int unsigned N_GP   = 80,
  parameter int unsigned GRP_SZ = 4,
  parameter int unsigned MAX_PT = 16,
  localparam int unsigned N_GRP   = N_MC / GRP_SZ,
  localparam int unsigned PER_GRP = N_GP / N_GRP
) (
  input  logic [N_GP-1:0]        pt_i,
  input  logic [N_GP*GRP_SZ-1:0] mask_i,
  output logic [N_MC-1:0]        sum_o
);
  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    localparam int unsigned GRP  = m / GRP_SZ;
    localparam int unsigned SLOT = m % GRP_SZ;
    logic acc;

    // lowest-indexed MAX_PT steered terms count, later ones are dropped
    always_comb begin
      int unsigned cnt;
      cnt = 0;
      acc = 1'b0;
      for (int j = 0; j < int'(PER_GRP); j++) begin
        if (mask_i[(GRP*PER_GRP + j)*GRP_SZ + SLOT]) begin
          if (cnt < MAX_PT) acc = acc | pt_i[GRP*PER_GRP + j];
          cnt = cnt + 1;
        end
      end
    end

    assign sum_o[m] = acc;
  end
endmodule

// File: rtl/pterm_lb_macrocell.sv
module pterm_lb_macrocell
  import pterm_lb_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     d_i,
  input  logic     pt_set_i,
  input  logic     pt_rst_i,
  input  logic     pt_clk_i,
  input  mc_mode_t mode_i,
  output logic     q_o
);
  logic mc_clk, clr, q_raw, reg_out;

  assign mc_clk = mode_i.pt_clk ? pt_clk_i : clk_i;
  assign clr    = !rst_ni | pt_rst_i;

  always_ff @(posedge mc_clk or posedge clr or posedge pt_set_i) begin
    if (clr)           q_raw <= 1'b0;
    else if (pt_set_i) q_raw <= 1'b1;
    else               q_raw <= d_i;
  end

  // level view of the async controls, reset first
  assign reg_out = pt_rst_i ? 1'b0 : (pt_set_i ? 1'b1 : q_raw);
  assign q_o     = mode_i.reg_en ? reg_out : d_i;

  // R9
  areset_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i.reg_en && pt_rst_i) |-> !q_o);

  // R8
  aset_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i.reg_en && pt_set_i && !pt_rst_i) |-> q_o);

  // R6
  global_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i.reg_en && !mode_i.pt_clk && $stable(mode_i) && !pt_set_i && !pt_rst_i
     && $past(!pt_set_i && !pt_rst_i)) |-> q_o == $past(d_i));
endmodule

// File: rtl/pterm_lb.sv
module pterm_lb
  import pterm_lb_pkg::*;
#(
  parameter int unsigned N_IN   = 36,
  parameter int unsigned N_MC   = 16,
  parameter int unsigned N_GP   = 80,
  parameter int unsigned GRP_SZ = 4,
  parameter int unsigned MAX_PT = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_en_i,
  input  logic            cfg_di_i,
  input  logic [N_IN-1:0] in_i,
  output logic [N_MC-1:0] mc_o
);
  localparam int unsigned N_LIT    = 2 * N_IN;
  localparam int unsigned N_PT     = N_GP + 3;
  localparam int unsigned PT_SET   = N_GP;
  localparam int unsigned PT_RST   = N_GP + 1;
  localparam int unsigned PT_CLK   = N_GP + 2;
  localparam int unsigned AND_W    = N_PT * N_LIT;
  localparam int unsigned STEER_W  = N_GP * GRP_SZ;
  localparam int unsigned MODE_W   = 2 * N_MC;
  localparam int unsigned MODE_LSB = AND_W + STEER_W;
  localparam int unsigned CFG_W    = AND_W + STEER_W + MODE_W;

  logic [CFG_W-1:0] cfg;
  logic             cfg_valid;
  logic [N_PT-1:0]  pt;
  logic [N_MC-1:0]  sum, mc_q;

  pterm_lb_cfg_chain #(.CFG_W(CFG_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_en_i (cfg_en_i),
    .cfg_di_i (cfg_di_i),
    .cfg_o    (cfg),
    .valid_o  (cfg_valid)
  );

  pterm_lb_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
    .in_i  (in_i),
    .sel_i (cfg[AND_W-1:0]),
    .en_i  (cfg_valid),
    .pt_o  (pt)
  );

  pterm_lb_steer #(
    .N_MC(N_MC), .N_GP(N_GP), .GRP_SZ(GRP_SZ), .MAX_PT(MAX_PT)
  ) u_steer (
    .pt_i   (pt[N_GP-1:0]),
    .mask_i (cfg[AND_W +: STEER_W]),
    .sum_o  (sum)
  );

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    pterm_lb_macrocell u_mc (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .d_i      (sum[m]),
      .pt_set_i (pt[PT_SET]),
      .pt_rst_i (pt[PT_RST]),
      .pt_clk_i (pt[PT_CLK]),
      .mode_i   (mc_mode_t'(cfg[MODE_LSB + 2*m +: 2])),
      .q_o      (mc_q[m])
    );
  end

  assign mc_o = cfg_valid ? mc_q : '0;

  // R10
  idle_while_loading_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> mc_o == '0);
endmodule

// File: tb/tb_pterm_lb.sv
`timescale 1ns/1ps
module tb_pterm_lb;
  localparam int N_IN = 36, N_MC = 16, N_GP = 80, GRP_SZ = 4, MAX_PT = 16;
  localparam int N_LIT = 2 * N_IN, N_PT = N_GP + 3;
  localparam int PER_GRP = N_GP / (N_MC / GRP_SZ);
  localparam int AND_W = N_PT * N_LIT, STEER_W = N_GP * GRP_SZ;
  localparam int MODE_LSB = AND_W + STEER_W;
  localparam int CFG_W = MODE_LSB + 2 * N_MC;

  logic clk = 1'b0, rst_n = 1'b0, cfg_en = 1'b0, cfg_di = 1'b0;
  logic [N_IN-1:0] in_v = '0;
  logic [N_MC-1:0] mc;
  logic [CFG_W-1:0] cfg;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pterm_lb dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .cfg_di_i(cfg_di),
    .in_i(in_v), .mc_o(mc)
  );

  task automatic chk(string req, logic [N_MC-1:0] act, logic [N_MC-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: mc_o=%h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic lit(int p, int l); cfg[p*N_LIT + l] = 1'b1; endtask
  task automatic steer(int t, int k); cfg[AND_W + t*GRP_SZ + k] = 1'b1; endtask
  task automatic mode(int m, bit reg_en, bit ptc);
    cfg[MODE_LSB + 2*m] = reg_en; cfg[MODE_LSB + 2*m + 1] = ptc;
  endtask

  task automatic load_cfg(bit gate_chk);
    @(negedge clk);
    cfg_en = 1'b1;
    for (int i = CFG_W - 1; i >= 0; i--) begin
      cfg_di = cfg[i];
      @(negedge clk);
      if (gate_chk && i == CFG_W - 3) chk("R10 outputs idle while loading", mc, '0);
    end
    cfg_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic model_pt(int p, logic [N_IN-1:0] v);
    logic any = 1'b0, all = 1'b1;
    for (int l = 0; l < N_LIT; l++)
      if (cfg[p*N_LIT + l]) begin
        any = 1'b1;
        all = all & ((l < N_IN) ? v[l] : ~v[l - N_IN]);
      end
    return any & all;
  endfunction

  function automatic logic [N_MC-1:0] model_sum(logic [N_IN-1:0] v);
    logic [N_MC-1:0] r = '0;
    for (int m = 0; m < N_MC; m++) begin
      int cnt = 0;
      for (int j = 0; j < PER_GRP; j++) begin
        int t = (m / GRP_SZ) * PER_GRP + j;
        if (cfg[AND_W + t*GRP_SZ + (m % GRP_SZ)]) begin
          if (cnt < MAX_PT) r[m] = r[m] | model_pt(t, v);
          cnt++;
        end
      end
    end
    return r;
  endfunction

  task automatic t_reset;
    #5 chk("R11 output low in reset", mc, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    in_v = '1;
    @(negedge clk); #2;
    chk("R10 idle before first load", mc, '0);
  endtask

  task automatic t_comb_random(int nlit);
    cfg = '0;
    for (int t = 0; t < N_GP; t++) begin
      for (int k = 0; k < nlit; k++) lit(t, int'($urandom_range(N_LIT - 1)));
      for (int k = 0; k < GRP_SZ; k++) if ($urandom_range(1)) steer(t, k);
    end
    load_cfg(1'b0);
    for (int n = 0; n < 24; n++) begin
      @(negedge clk);
      in_v = N_IN'({$urandom(), $urandom()});
      #2 chk("R1 R3 random sum of products", mc, model_sum(in_v));
    end
  endtask

  task automatic t_unprog;
    cfg = '0;
    for (int t = 0; t < N_GP; t++) for (int k = 0; k < GRP_SZ; k++) steer(t, k);
    load_cfg(1'b0);
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      in_v = (n == 0) ? '0 : (n == 1) ? '1 : N_IN'({$urandom(), $urandom()});
      #2 chk("R2 blank terms read 0", mc, '0);
    end
  endtask

  task automatic t_cap;
    logic [N_MC-1:0] exp;
    cfg = '0;
    for (int t = 0; t < PER_GRP; t++) steer(t, 0);
    for (int t = 16; t < PER_GRP; t++) lit(t, 0);
    steer(19, 1);
    lit(20, 1);      steer(20, 0);
    lit(35, N_IN+1); steer(35, 1);
    load_cfg(1'b0);
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      in_v = '0; in_v[0] = n[0]; in_v[1] = n[1];
      exp = '0; exp[1] = in_v[0]; exp[4] = in_v[1]; exp[5] = ~in_v[1];
      #2 chk("R4 cap of 16 terms, R3 sharing", mc, exp);
    end
    @(negedge clk); in_v = '0; in_v[0] = 1'b1;
    #2 chk("R3 shared term before reload", mc, 16'h0022);
  endtask

  task automatic t_regs;
    cfg = '0;
    lit(0, 0); steer(0, 0); steer(0, 1); steer(0, 3);
    lit(N_GP, 33); lit(N_GP + 1, 34); lit(N_GP + 2, 35);
    mode(0, 1, 1); mode(1, 1, 0); mode(2, 1, 0); mode(3, 0, 0);
    load_cfg(1'b1);
    in_v = '0;
    @(negedge clk); #2 chk("R6 R7 registers start low", mc, '0);
    in_v[0] = 1'b1;
    #2 chk("R5 comb follows at once, R6 waits for edge", mc, 16'h0008);
    @(negedge clk); #2 chk("R6 global capture, R7 no pt edge", mc, 16'h000A);
    in_v[35] = 1'b1;
    #2 chk("R7 captured on pt clock edge", mc, 16'h000B);
    in_v[35] = 1'b0; in_v[0] = 1'b0;
    @(negedge clk); #2 chk("R7 holds without pt edge", mc, 16'h0001);
    in_v[33] = 1'b1;
    #2 chk("R8 async set, comb unaffected", mc, 16'h0007);
    @(negedge clk); #2 chk("R8 set held over clock", mc, 16'h0007);
    in_v[33] = 1'b0;
    @(negedge clk); #2 chk("R8 release then global capture", mc, 16'h0001);
    in_v[34] = 1'b1;
    #2 chk("R9 async reset", mc, 16'h0000);
    in_v[33] = 1'b1;
    #2 chk("R9 reset wins over set", mc, 16'h0000);
    @(negedge clk); #2 chk("R9 reset wins over clock", mc, 16'h0000);
    in_v[33] = 1'b0;
    @(negedge clk); in_v[34] = 1'b0;
    @(negedge clk); #2 chk("R9 stays low after release", mc, 16'h0000);
  endtask

  task automatic t_mid_reset;
    in_v = '0; in_v[0] = 1'b1;
    @(negedge clk); #2 chk("R11 pre-reset comb high", mc[3], 1'b1);
    rst_n = 1'b0;
    #2 chk("R11 reset clears outputs", mc, '0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk); #2 chk("R11 configuration cleared", mc, '0);
  endtask

  initial begin
    t_reset();
    t_comb_random(3);
    t_comb_random(4);
    t_unprog();
    t_cap();
    t_regs();
    t_mid_reset();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule